// File: doc/BRIEF.md
# Shared Buffer Ownership Arbiter

This block decides which of two masters may reach a single-port buffer SRAM. The acquisition master holds the memory by default and writes samples into it. A processing master can borrow the buffer. It pulls an active-low request line and waits until an acknowledge line rises. It then reads or writes through its own isolated path, using a level line to choose the data direction. It raises a done line when it has finished. The owner may hold off a request until a local release-permission input allows the grant.

The arbiter drives the bus-select line and the two path-isolation enables, and it steers the borrower's data transceiver direction. It also stalls the acquisition write stream while the memory is lent out. Every ownership change passes through a configurable number of idle cycles in which neither path is connected. The request and done lines come from another board, so each passes through a synchronizer whose depth is set by a parameter.

Top module: `sba_arbiter`

## Requirements
- R1: With `rel_ok` high and the synchronized done line low, a low level on `brw_req_n` raises `brw_ack`, `bus_sel` and `brw_path_en` on the (SYNC_STAGES+GAP_CYCLES+1)-th rising clock edge after the request falls.
- R2: While `rel_ok` is low, a pending request gets no acknowledge, and acquisition keeps running with `acq_path_en` high and `acq_stall` low. Once `rel_ok` rises with the request already synchronized, the grant appears on the (GAP_CYCLES+1)-th edge.
- R3: While `bus_sel` is low, only the acquisition path may be enabled. `brw_path_en` is high only in cycles where both `bus_sel` and `brw_ack` are high.
- R4: While the buffer is lent, `brw_dir_rd` follows `brw_rd` in the same cycle (1 = read, 0 = write). In every other state it stays at 1 whatever `brw_rd` does.
- R5: A high level on `brw_done` drops `brw_ack`, `bus_sel` and `brw_path_en` on the (SYNC_STAGES+1)-th edge. `acq_path_en` returns high and `acq_stall` low GAP_CYCLES edges after that.
- R6: `acq_path_en` and `brw_path_en` are never high in the same cycle. Each ownership change has GAP_CYCLES cycles in which both are low.
- R7: `acq_stall` is high from the grant decision until acquisition resumes. `acq_wr_accept` equals `acq_wr_req` gated by the absence of a stall. A write request held through the lent interval is accepted afterwards, so no write is lost.
- R8: During reset, `brw_ack`, `bus_sel`, `brw_path_en` and `acq_stall` are 0, while `acq_path_en` and `brw_dir_rd` are 1.
- R9: No grant is made while the synchronized done line is high. A request held low with `brw_done` high gets no acknowledge until done falls. The grant then follows the R1 latency, counted from the fall of done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| brw_req_n | input | 1 | Borrower request, active low, asynchronous |
| brw_done | input | 1 | Borrower finished, active high, asynchronous |
| brw_rd | input | 1 | Borrower data direction, 1 read, 0 write |
| rel_ok | input | 1 | Owner allows the buffer to be released |
| acq_wr_req | input | 1 | Acquisition write request, held until accepted |
| brw_ack | output | 1 | Grant acknowledge to the borrower |
| bus_sel | output | 1 | Memory bus select, 1 = borrower bus |
| acq_path_en | output | 1 | Acquisition address/data isolation enable |
| brw_path_en | output | 1 | Borrower address/data isolation enable |
| brw_dir_rd | output | 1 | Borrower data transceiver direction, 1 toward borrower |
| acq_stall | output | 1 | Acquisition writes held off |
| acq_wr_accept | output | 1 | Acquisition write taken on this edge |

## Verification
The checks assume the borrower follows the handshake. It raises done only while acknowledged, lowers its request no later than it raises done, and keeps done low for at least SYNC_STAGES+1 cycles before asking again. The checks also assume the acquisition side holds `acq_wr_req` until it sees an accept. The bench keeps to these rules. A scripted borrower waits for the acknowledge and then runs a session of random length. It returns done to low only after reclaim and idles for the synchronizer depth before its next request. A writer process drops or renews its request only on the cycle after an accept. Random `rel_ok` delays and random direction toggles vary the timing inside those rules.

// File: rtl/sba_pkg.sv
package sba_pkg;

   typedef enum logic [1:0] {
      SBA_ACQ     = 2'd0,
      SBA_GAP_OUT = 2'd1,
      SBA_LENT    = 2'd2,
      SBA_GAP_IN  = 2'd3
   } sba_state_e;

   typedef struct packed {
      logic acq_en;
      logic brw_en;
      logic ack;
      logic sel;
      logic stall;
   } sba_ctl_t;

endpackage

// File: rtl/sba_sync.sv
module sba_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q <= {STAGES{RST_VAL}};
            end else begin
               chain_q <= {chain_q[STAGES-2:0], din};
            end
         end
         assign dout = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/sba_gap_timer.sv
module sba_gap_timer #(
   parameter int GAP_CYCLES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic last
);

   localparam int CNT_W = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;
   localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(GAP_CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (start) begin
         cnt_q <= LOAD_VAL;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign last = (cnt_q == '0);

endmodule

// File: rtl/sba_fsm.sv
module sba_fsm
   import sba_pkg::*;
#(
   parameter int GAP_CYCLES = 1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     req_act,
   input  logic     done_s,
   input  logic     rel_ok,
   output sba_ctl_t ctl
);

   sba_state_e st_q, st_d;
   logic       gap_start;
   logic       gap_last;

   sba_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) gap_i (
      .clk   (clk),
      .rst_n (rst_n),
      .start (gap_start),
      .last  (gap_last)
   );

   always_comb begin
      st_d      = st_q;
      gap_start = 1'b0;
      unique case (st_q)
         SBA_ACQ: begin
            if (req_act && rel_ok && !done_s) begin
               st_d      = SBA_GAP_OUT;
               gap_start = 1'b1;
            end
         end
         SBA_GAP_OUT: begin
            if (gap_last) st_d = SBA_LENT;
         end
         SBA_LENT: begin
            if (done_s) begin
               st_d      = SBA_GAP_IN;
               gap_start = 1'b1;
            end
         end
         SBA_GAP_IN: begin
            if (gap_last) st_d = SBA_ACQ;
         end
         default: st_d = SBA_ACQ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= SBA_ACQ;
      end else begin
         st_q <= st_d;
      end
   end

   always_comb begin
      ctl.acq_en = (st_q == SBA_ACQ);
      ctl.stall  = (st_q != SBA_ACQ);
      ctl.brw_en = (st_q == SBA_LENT);
      ctl.ack    = (st_q == SBA_LENT);
      ctl.sel    = (st_q == SBA_LENT);
   end

endmodule

// File: rtl/sba_arbiter.sv
module sba_arbiter
   import sba_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int GAP_CYCLES  = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic brw_req_n,
   input  logic brw_done,
   input  logic brw_rd,
   input  logic rel_ok,
   input  logic acq_wr_req,
   output logic brw_ack,
   output logic bus_sel,
   output logic acq_path_en,
   output logic brw_path_en,
   output logic brw_dir_rd,
   output logic acq_stall,
   output logic acq_wr_accept
);

   generate
      if (GAP_CYCLES < 1) begin : g_bad_gap
         $error("sba_arbiter: GAP_CYCLES must be at least 1");
      end
      if (SYNC_STAGES == 1 || SYNC_STAGES < 0) begin : g_bad_sync
         $error("sba_arbiter: SYNC_STAGES must be 0 or 2 and above");
      end
   endgenerate

   logic     req_n_s;
   logic     done_s;
   sba_ctl_t ctl;

   sba_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) req_sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (brw_req_n),
      .dout  (req_n_s)
   );

   sba_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) done_sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (brw_done),
      .dout  (done_s)
   );

   sba_fsm #(.GAP_CYCLES(GAP_CYCLES)) fsm_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_act (!req_n_s),
      .done_s  (done_s),
      .rel_ok  (rel_ok),
      .ctl     (ctl)
   );

   assign brw_ack       = ctl.ack;
   assign bus_sel       = ctl.sel;
   assign acq_path_en   = ctl.acq_en;
   assign brw_path_en   = ctl.brw_en;
   assign acq_stall     = ctl.stall;
   assign brw_dir_rd    = ctl.brw_en ? brw_rd : 1'b1;
   assign acq_wr_accept = acq_wr_req && !ctl.stall;

endmodule

// File: rtl/sba_arbiter_chk.sv
module sba_arbiter_chk (
   input logic clk,
   input logic rst_n,
   input logic brw_ack,
   input logic bus_sel,
   input logic acq_path_en,
   input logic brw_path_en,
   input logic brw_dir_rd,
   input logic acq_stall,
   input logic acq_wr_accept
);

   logic seen_edge = 1'b0;
   always @(posedge clk) seen_edge <= 1'b1;

   // R8
   always @(negedge clk) begin
      if (!rst_n && seen_edge) begin
         rst_idle_chk: assert (!brw_ack && !bus_sel && !brw_path_en && !acq_stall
                               && acq_path_en && brw_dir_rd)
            else $error("R8 outputs not idle in reset");
      end
   end

   // R6
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(acq_path_en && brw_path_en));

   // R6
   gap_before_lend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(brw_path_en) |-> $past(!acq_path_en));

   // R6
   gap_before_reclaim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(acq_path_en) |-> $past(!brw_path_en));

   // R3
   sel_low_isolates_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_sel |-> !brw_path_en);

   // R5
   ack_fall_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(brw_ack) |-> (!brw_path_en && !acq_path_en && !bus_sel));

   // R7
   lend_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      brw_ack |-> !acq_wr_accept);

   // R7
   stall_before_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(brw_ack) |-> $past(acq_stall));

   // R7
   resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(acq_stall) |-> acq_path_en);

endmodule

bind sba_arbiter sba_arbiter_chk chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .brw_ack       (brw_ack),
   .bus_sel       (bus_sel),
   .acq_path_en   (acq_path_en),
   .brw_path_en   (brw_path_en),
   .brw_dir_rd    (brw_dir_rd),
   .acq_stall     (acq_stall),
   .acq_wr_accept (acq_wr_accept)
);

// File: tb/sba_arbiter_tb_top.sv
module sba_arbiter_tb_top;

   localparam int SYNC = 2;
   localparam int GAP  = 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic brw_req_n = 1'b1;
   logic brw_done = 1'b0;
   logic brw_rd = 1'b1;
   logic rel_ok = 1'b1;
   logic acq_wr_req = 1'b0;
   logic brw_ack, bus_sel, acq_path_en, brw_path_en, brw_dir_rd, acq_stall, acq_wr_accept;

   int checks = 0;
   int failures = 0;
   int issued = 0;
   int accepted = 0;
   bit wr_run = 1'b0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   sba_arbiter #(.SYNC_STAGES(SYNC), .GAP_CYCLES(GAP)) dut_i (
      .clk(clk), .rst_n(rst_n), .brw_req_n(brw_req_n), .brw_done(brw_done),
      .brw_rd(brw_rd), .rel_ok(rel_ok), .acq_wr_req(acq_wr_req),
      .brw_ack(brw_ack), .bus_sel(bus_sel), .acq_path_en(acq_path_en),
      .brw_path_en(brw_path_en), .brw_dir_rd(brw_dir_rd), .acq_stall(acq_stall),
      .acq_wr_accept(acq_wr_accept)
   );

   function automatic int grant_lat(input int rel_delay);
      return ((rel_delay > SYNC) ? rel_delay : SYNC) + 1 + GAP;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic lent_state_chk(input string req);
      chk(brw_ack && bus_sel && brw_path_en && !acq_path_en && acq_stall, req,
          {brw_ack, bus_sel, brw_path_en, acq_path_en, acq_stall}, 5'b11101);
   endtask

   // acquisition writer: holds its request until accepted
   initial begin
      bit took = 1'b0;
      forever begin
         @(negedge clk);
         if (took) begin
            took = 1'b0;
            accepted++;
            acq_wr_req = wr_run && ($urandom % 2 == 0);
            if (acq_wr_req) issued++;
         end else if (acq_wr_req) begin
            // R7: never accepted while lent
            if (acq_wr_accept && brw_ack) chk(1'b0, "R7 accept while lent", 1, 0);
            took = acq_wr_accept;
         end else if (wr_run && ($urandom % 3 == 0)) begin
            acq_wr_req = 1'b1;
            issued++;
         end
      end
   end

   // one borrower session; rel_ok rises rel_delay cycles after the request
   task automatic session(input int rel_delay, input int hold);
      int exp = grant_lat(rel_delay);
      rel_ok = (rel_delay == 0);
      brw_req_n = 1'b0;
      for (int k = 1; k <= exp; k++) begin
         @(negedge clk);
         if (k < exp) chk(!brw_ack && !brw_path_en, "R1 early ack", brw_ack, 0);
         if (k == rel_delay) rel_ok = 1'b1;
      end
      lent_state_chk("R1 grant latency");
      for (int c = 0; c < hold; c++) begin
         brw_rd = 1'($urandom);
         #1;
         chk(brw_dir_rd == brw_rd, "R4 dir follows", brw_dir_rd, brw_rd);
         @(negedge clk);
         chk(!acq_path_en && acq_stall, "R3 acq isolated while lent", acq_path_en, 0);
      end
      brw_done = 1'b1;
      brw_req_n = 1'b1;
      for (int k = 1; k <= SYNC + 1 + GAP; k++) begin
         @(negedge clk);
         if (k == SYNC) chk(brw_ack, "R5 ack held until done synced", brw_ack, 1);
         if (k == SYNC + 1)
            chk(!brw_ack && !bus_sel && !brw_path_en && !acq_path_en, "R6 reclaim gap",
                {brw_ack, bus_sel, brw_path_en, acq_path_en}, 0);
      end
      chk(acq_path_en && !acq_stall, "R5 acquisition resumed", {acq_path_en, acq_stall}, 2);
      brw_done = 1'b0;
      rel_ok = 1'($urandom);
      repeat (SYNC + 1) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         chk(1'b0, "watchdog", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R8 reset state
      chk(!brw_ack && !bus_sel && !brw_path_en && !acq_stall && acq_path_en && brw_dir_rd,
          "R8 reset outputs", {brw_ack, bus_sel, brw_path_en, acq_stall, acq_path_en, brw_dir_rd}, 3);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R4 direction ignored when not lent
      brw_rd = 1'b0;
      #1;
      chk(brw_dir_rd == 1'b1, "R4 idle dir", brw_dir_rd, 1);
      brw_rd = 1'b1;

      // R1 basic grant
      wr_run = 1'b1;
      session(0, 3);

      // R2 owner withholds release
      rel_ok = 1'b0;
      brw_req_n = 1'b0;
      repeat (10) @(negedge clk);
      chk(!brw_ack && acq_path_en && !acq_stall, "R2 pending no ack",
          {brw_ack, acq_path_en, acq_stall}, 2);
      rel_ok = 1'b1;
      for (int k = 1; k <= GAP + 1; k++) begin
         @(negedge clk);
         if (k == GAP + 1) lent_state_chk("R2 grant after release");
         else chk(!brw_ack, "R2 early ack", brw_ack, 0);
      end
      brw_done = 1'b1;
      brw_req_n = 1'b1;
      repeat (SYNC + 1 + GAP) @(negedge clk);
      chk(acq_path_en, "R5 reclaimed", acq_path_en, 1);

      // R9 request while done still high
      brw_req_n = 1'b0;
      repeat (12) @(negedge clk);
      chk(!brw_ack && acq_path_en, "R9 no grant while done high", brw_ack, 0);
      brw_done = 1'b0;
      for (int k = 1; k <= grant_lat(0); k++) begin
         @(negedge clk);
         if (k < grant_lat(0)) chk(!brw_ack, "R9 early ack", brw_ack, 0);
      end
      lent_state_chk("R9 grant after done fell");
      brw_done = 1'b1;
      brw_req_n = 1'b1;
      repeat (SYNC + 1 + GAP) @(negedge clk);
      brw_done = 1'b0;
      repeat (SYNC + 1) @(negedge clk);

      // random sessions
      for (int s = 0; s < 40; s++) begin
         repeat ($urandom % 6) @(negedge clk);
         session(int'($urandom % 6), 2 + int'($urandom % 6));
      end

      // R7 drain: every issued write is accepted
      wr_run = 1'b0;
      repeat (10) @(negedge clk);
      chk(issued == accepted, "R7 no write lost", accepted, issued);
      chk(issued > 20, "R7 write traffic present", issued, 21);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule